// File: doc/BRIEF.md
# Busy-Gated UART Configuration Register Front End

This block is the register front end of a 16550-style UART. It owns the line control register and the 16-bit baud divisor, and it decides when a software write to either may reach the serializer. The UART counts as busy when the transmitter is shifting, the receiver is taking in a character, or the transmit FIFO holds data. While busy, configuration writes are normally discarded. An optional staging mode holds such writes in shadow copies and loads them together when software writes a self-clearing update bit. The block also handles the divisor-latch access bit, which remaps the two low offsets. It holds the interrupt-enable byte, the modem-control byte with a loopback request that waits for the receiver to go idle, and the strobes that clear the FIFOs.

Software that wants to change the baud rate while traffic may be present has two options. It can use the staging mode. It can also force the UART idle by requesting loopback and clearing both FIFOs, poll the busy flag, and then write directly. Reading back the line control register shows the value in effect, so a write that was discarded can be detected.

Top module: `uart_cfg_front`

## Requirements
- R1: The busy flag is the OR of `tx_shifting`, `rx_active` and a non-empty transmit FIFO (`tx_fifo_empty` low). It reads as bit 0 at offset 7, and a read there changes no state.
- R2: With staging disabled and busy high, writes to the line control register (offset 3) and to either divisor byte are discarded. A read of offset 3 keeps returning the earlier value.
- R3: With staging disabled and busy low, a write to offset 3 or to a divisor byte takes effect on the capturing clock edge and appears on `line_ctrl` / `divisor` after that edge.
- R4: Offset 6 is the staging control: bit 0 enables staging and bit 1 requests an update. While staging is enabled, writes to the line control register and the divisor change only the shadow copies, and `line_ctrl`, `divisor` and the offset-3 readback stay unchanged.
- R5: Writing offset 6 with bits 0 and 1 both set loads the shadow line control and shadow divisor into the active registers on the same clock edge, one cycle after the write. Bit 1 reads 1 for that one cycle and then 0. A write with bit 1 set and bit 0 clear applies nothing.
- R6: Bit 7 of the line control value (shadow copy) is the divisor-latch access bit. When it is set, offsets 0 and 1 are the divisor low and high bytes. When it is clear, a write to offset 0 pulses `tx_push`, a read of offset 0 returns `rx_data`, and offset 1 is the interrupt-enable byte (`int_en`). A high-byte write made after a discarded bit-7 write therefore lands in `int_en`.
- R7: Bit 4 of the modem-control byte (offset 4) requests loopback. `loopback` takes the requested value on the first clock edge at which `rx_active` is low, and holds while `rx_active` is high.
- R8: A write to offset 2 drives `clr_rx_fifo` from data bit 1 and `clr_tx_fifo` from data bit 2, during the write cycle only.
- R9: With the parameter `NO_BUSY_GATE` set, writes to the line control register and the divisor are never discarded for busy.
- R10: After reset `line_ctrl` is 0x03, `divisor` is 0x0001, `int_en` is 0, `loopback` is 0 and offset 6 reads 0.
- R11: Writing offset 6 with bit 0 clear discards any staged values: the shadow copies reload from the active registers, so bit 7 decoding follows the active line control value again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| tx_shifting | input | 1 | Transmitter is shifting a character |
| rx_active | input | 1 | Receiver is taking in a character |
| tx_fifo_empty | input | 1 | Transmit FIFO is empty |
| rx_data | input | 8 | Receive data returned at offset 0 |
| line_ctrl | output | 8 | Active frame format to the serializer |
| divisor | output | 16 | Active baud divisor |
| int_en | output | 8 | Interrupt-enable byte |
| loopback | output | 1 | Loopback in effect |
| tx_push | output | 1 | Transmit data write strobe (data on `reg_wdata`) |
| clr_rx_fifo | output | 1 | Receive FIFO clear pulse |
| clr_tx_fifo | output | 1 | Transmit FIFO clear pulse |

## Verification
A register write takes effect on the edge that captures it. The bench drives each write between two falling edges and reads back or samples the outputs at the next falling edge. Reads are combinational on the offset, so each readback is taken a moment after the address settles within one low phase. A staged update shows its pending bit at the first falling edge after the write and the new `line_ctrl`/`divisor` only at the second, and the bench samples both points. Loopback is sampled one edge after `rx_active` drops, and the FIFO-clear strobes are sampled inside the write cycle itself.

// File: rtl/uart_cfg_pkg.sv
// Shared offsets, bit positions and decode type for the UART configuration
// front end. Assumes an 8-bit register bus with eight offsets.
package uart_cfg_pkg;
    localparam int unsigned REG_AW = 3;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned DIV_W  = 2 * BYTE_W;

    localparam logic [REG_AW-1:0] OFS_DATA = 3'd0;
    localparam logic [REG_AW-1:0] OFS_HIGH = 3'd1;
    localparam logic [REG_AW-1:0] OFS_FIFO = 3'd2;
    localparam logic [REG_AW-1:0] OFS_LCR  = 3'd3;
    localparam logic [REG_AW-1:0] OFS_MCR  = 3'd4;
    localparam logic [REG_AW-1:0] OFS_CTRL = 3'd6;
    localparam logic [REG_AW-1:0] OFS_STAT = 3'd7;

    localparam int unsigned LCR_DLAB_BIT = 7;
    localparam int unsigned MCR_LOOP_BIT = 4;
    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_UPD_BIT = 1;
    localparam int unsigned FCR_RX_BIT   = 1;
    localparam int unsigned FCR_TX_BIT   = 2;

    typedef struct packed {
        logic tx;
        logic dll;
        logic dlm;
        logic ier;
        logic fcr;
        logic lcr;
        logic mcr;
        logic ctrl;
    } wr_sel_t;
endpackage

// File: rtl/ucfg_decode.sv
// Address decode and read multiplexer. Turns a bus write into one-hot
// register strobes, with offsets 0 and 1 remapped by the access bit.
// Assumes reads are free of side effects and combinational.
module ucfg_decode
    import uart_cfg_pkg::*;
(
    input  logic [REG_AW-1:0] addr,
    input  logic              wr,
    input  logic              dlab,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic [DIV_W-1:0]  div_act,
    input  logic [BYTE_W-1:0] lcr_act,
    input  logic [BYTE_W-1:0] ier,
    input  logic [BYTE_W-1:0] mcr,
    input  logic              stage_en,
    input  logic              upd_pend,
    input  logic              busy,
    output wr_sel_t           sel,
    output logic [BYTE_W-1:0] rdata
);
    // Write strobe per register.
    always_comb begin
        sel      = '0;
        sel.tx   = wr && (addr == OFS_DATA) && !dlab;
        sel.dll  = wr && (addr == OFS_DATA) &&  dlab;
        sel.dlm  = wr && (addr == OFS_HIGH) &&  dlab;
        sel.ier  = wr && (addr == OFS_HIGH) && !dlab;
        sel.fcr  = wr && (addr == OFS_FIFO);
        sel.lcr  = wr && (addr == OFS_LCR);
        sel.mcr  = wr && (addr == OFS_MCR);
        sel.ctrl = wr && (addr == OFS_CTRL);
    end

    // Read data selection.
    always_comb begin
        rdata = '0;
        case (addr)
            OFS_DATA: rdata = dlab ? div_act[BYTE_W-1:0] : rx_data;
            OFS_HIGH: rdata = dlab ? div_act[DIV_W-1:BYTE_W] : ier;
            OFS_LCR:  rdata = lcr_act;
            OFS_MCR:  rdata = mcr;
            OFS_CTRL: begin
                rdata[CTRL_EN_BIT]  = stage_en;
                rdata[CTRL_UPD_BIT] = upd_pend;
            end
            OFS_STAT: rdata[0] = busy;
            default:  rdata = '0;
        endcase
    end

    // R6: offset-1 writes never reach both the high divisor byte and IER.
    always_comb begin
        a_dlm_ier_excl_r6: assert (!(sel.dlm && sel.ier));
    end
endmodule

// File: rtl/ucfg_cfg_bank.sv
// Line control and divisor registers with shadow copies, busy gating and
// the self-clearing update. Shadow equals active whenever nothing is staged.
// Assumes at most one register write per cycle.
module ucfg_cfg_bank
    import uart_cfg_pkg::*;
#(
    parameter bit                NO_BUSY_GATE = 1'b0,
    parameter logic [BYTE_W-1:0] LCR_RST      = 8'h03,
    parameter logic [DIV_W-1:0]  DIV_RST      = 16'h0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_sel_t           sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              busy,
    output logic [BYTE_W-1:0] lcr_act_q,
    output logic [DIV_W-1:0]  div_act_q,
    output logic              sh_dlab,
    output logic              stage_en_q,
    output logic              upd_pend_q
);
    logic [BYTE_W-1:0] lcr_sh_q, lcr_sh_n;
    logic [DIV_W-1:0]  div_sh_q, div_sh_n;
    logic              drop;
    logic              direct_ok;
    logic              discard;

    // Variant choice: busy gating present or removed at build time.
    generate
        if (NO_BUSY_GATE) begin : g_nogate
            assign drop = 1'b0;
        end else begin : g_gate
            assign drop = busy;
        end
    endgenerate

    assign direct_ok = !stage_en_q && !drop;
    assign discard   = sel.ctrl && !wdata[CTRL_EN_BIT];
    assign sh_dlab   = lcr_sh_q[LCR_DLAB_BIT];

    // Next shadow value: discard reload, then accepted writes.
    always_comb begin
        lcr_sh_n = lcr_sh_q;
        div_sh_n = div_sh_q;
        if (discard && !upd_pend_q) begin
            lcr_sh_n = lcr_act_q;
            div_sh_n = div_act_q;
        end
        if (stage_en_q || direct_ok) begin
            if (sel.lcr) lcr_sh_n = wdata;
            if (sel.dll) div_sh_n[BYTE_W-1:0] = wdata;
            if (sel.dlm) div_sh_n[DIV_W-1:BYTE_W] = wdata;
        end
    end

    // Shadow registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr_sh_q <= LCR_RST;
            div_sh_q <= DIV_RST;
        end else begin
            lcr_sh_q <= lcr_sh_n;
            div_sh_q <= div_sh_n;
        end
    end

    // Active registers: atomic apply or direct write when allowed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcr_act_q <= LCR_RST;
            div_act_q <= DIV_RST;
        end else if (upd_pend_q) begin
            lcr_act_q <= lcr_sh_q;
            div_act_q <= div_sh_q;
        end else if (direct_ok) begin
            if (sel.lcr) lcr_act_q <= wdata;
            if (sel.dll) div_act_q[BYTE_W-1:0] <= wdata;
            if (sel.dlm) div_act_q[DIV_W-1:BYTE_W] <= wdata;
        end
    end

    // Staging enable and the one-cycle update request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_en_q <= 1'b0;
            upd_pend_q <= 1'b0;
        end else begin
            if (sel.ctrl) stage_en_q <= wdata[CTRL_EN_BIT];
            upd_pend_q <= sel.ctrl && wdata[CTRL_EN_BIT] && wdata[CTRL_UPD_BIT];
        end
    end

    // R2: a busy cycle without staging leaves the configuration unchanged.
    p_drop_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!NO_BUSY_GATE && busy && !stage_en_q && !upd_pend_q)
        |=> ($stable(lcr_act_q) && $stable(div_act_q)));

    // R4: while staging with no update pending, outputs hold.
    p_stage_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_en_q && !upd_pend_q)
        |=> ($stable(lcr_act_q) && $stable(div_act_q)));

    // R5: an update loads both shadow values on one edge.
    p_apply_both_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pend_q
        |=> ((lcr_act_q == $past(lcr_sh_q)) && (div_act_q == $past(div_sh_q))));

    // R9: without gating a direct line-control write always lands.
    p_nogate_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (NO_BUSY_GATE && sel.lcr && !stage_en_q && !upd_pend_q)
        |=> (lcr_act_q == $past(wdata)));
endmodule

// File: rtl/ucfg_loopback.sv
// Modem-control byte and the loopback that follows its request only while
// the receiver is idle, so a character in flight is never cut.
module ucfg_loopback
    import uart_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mcr_wr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rx_active,
    output logic [BYTE_W-1:0] mcr_q,
    output logic              loop_q
);
    // Modem-control byte as written.
    always_ff @(posedge clk) begin
        if (!rst_n)      mcr_q <= '0;
        else if (mcr_wr) mcr_q <= wdata;
    end

    // Loopback takes the request once the receiver is idle.
    always_ff @(posedge clk) begin
        if (!rst_n)          loop_q <= 1'b0;
        else if (!rx_active) loop_q <= mcr_q[MCR_LOOP_BIT];
    end

    // R7: loopback never changes while a character is being received.
    p_loop_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_active |=> $stable(loop_q));
endmodule

// File: rtl/uart_cfg_front.sv
// Top of the UART configuration front end: busy detection, decode,
// gated configuration bank, interrupt-enable byte, loopback and FIFO
// clear strobes. Assumes status inputs are synchronous to clk.
module uart_cfg_front
    import uart_cfg_pkg::*;
#(
    parameter bit           NO_BUSY_GATE = 1'b0,
    parameter logic [7:0]   LCR_RST      = 8'h03,
    parameter logic [15:0]  DIV_RST      = 16'h0001
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic        tx_shifting,
    input  logic        rx_active,
    input  logic        tx_fifo_empty,
    input  logic [7:0]  rx_data,
    output logic [7:0]  line_ctrl,
    output logic [15:0] divisor,
    output logic [7:0]  int_en,
    output logic        loopback,
    output logic        tx_push,
    output logic        clr_rx_fifo,
    output logic        clr_tx_fifo
);
    wr_sel_t           sel;
    logic              busy;
    logic              sh_dlab;
    logic              stage_en;
    logic              upd_pend;
    logic [BYTE_W-1:0] ier_q;
    logic [BYTE_W-1:0] mcr_q;

    assign busy        = tx_shifting || rx_active || !tx_fifo_empty;
    assign tx_push     = sel.tx;
    assign clr_rx_fifo = sel.fcr && reg_wdata[FCR_RX_BIT];
    assign clr_tx_fifo = sel.fcr && reg_wdata[FCR_TX_BIT];
    assign int_en      = ier_q;

    ucfg_decode u_decode (
        .addr     (reg_addr),
        .wr       (reg_wr),
        .dlab     (sh_dlab),
        .rx_data  (rx_data),
        .div_act  (divisor),
        .lcr_act  (line_ctrl),
        .ier      (ier_q),
        .mcr      (mcr_q),
        .stage_en (stage_en),
        .upd_pend (upd_pend),
        .busy     (busy),
        .sel      (sel),
        .rdata    (reg_rdata)
    );

    ucfg_cfg_bank #(
        .NO_BUSY_GATE (NO_BUSY_GATE),
        .LCR_RST      (LCR_RST),
        .DIV_RST      (DIV_RST)
    ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel        (sel),
        .wdata      (reg_wdata),
        .busy       (busy),
        .lcr_act_q  (line_ctrl),
        .div_act_q  (divisor),
        .sh_dlab    (sh_dlab),
        .stage_en_q (stage_en),
        .upd_pend_q (upd_pend)
    );

    ucfg_loopback u_loop (
        .clk       (clk),
        .rst_n     (rst_n),
        .mcr_wr    (sel.mcr),
        .wdata     (reg_wdata),
        .rx_active (rx_active),
        .mcr_q     (mcr_q),
        .loop_q    (loopback)
    );

    // Interrupt-enable byte, written through offset 1 with the access bit clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       ier_q <= '0;
        else if (sel.ier) ier_q <= reg_wdata;
    end

    // R5: the update request never lasts two cycles without a fresh write.
    p_upd_selfclr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_pend && !sel.ctrl) |=> !upd_pend);
endmodule

// File: tb/uart_cfg_front_tb_top.sv
module uart_cfg_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        tx_shifting = 1'b0;
    logic        rx_active = 1'b0;
    logic        tx_fifo_empty = 1'b1;
    logic [7:0]  rx_data = 8'hA5;
    logic [7:0]  reg_rdata, line_ctrl, int_en;
    logic [15:0] divisor;
    logic        loopback, tx_push, clr_rx_fifo, clr_tx_fifo;
    logic [7:0]  c_rdata, c_line_ctrl, c_int_en;
    logic [15:0] c_divisor;
    logic        c_loopback, c_tx_push, c_clr_rx, c_clr_tx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    uart_cfg_front dut_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_shifting(tx_shifting),
        .rx_active(rx_active), .tx_fifo_empty(tx_fifo_empty), .rx_data(rx_data),
        .line_ctrl(line_ctrl), .divisor(divisor), .int_en(int_en),
        .loopback(loopback), .tx_push(tx_push), .clr_rx_fifo(clr_rx_fifo),
        .clr_tx_fifo(clr_tx_fifo)
    );

    uart_cfg_front #(.NO_BUSY_GATE(1'b1)) dut_compat_i (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(c_rdata), .tx_shifting(tx_shifting),
        .rx_active(rx_active), .tx_fifo_empty(tx_fifo_empty), .rx_data(rx_data),
        .line_ctrl(c_line_ctrl), .divisor(c_divisor), .int_en(c_int_en),
        .loopback(c_loopback), .tx_push(c_tx_push), .clr_rx_fifo(c_clr_rx),
        .clr_tx_fifo(c_clr_tx)
    );

    // Vector: {req[26:23], busy[22], addr[21:19], wdata[18:11], chk_addr[10:8], exp[7:0]}
    localparam int NV = 11;
    localparam logic [26:0] VEC [NV] = '{
        {4'd3, 1'b0, 3'd3, 8'h83, 3'd3, 8'h83},  // R3 set access bit
        {4'd6, 1'b0, 3'd0, 8'h1B, 3'd0, 8'h1B},  // R6 divisor low
        {4'd6, 1'b0, 3'd1, 8'h02, 3'd1, 8'h02},  // R6 divisor high
        {4'd2, 1'b1, 3'd0, 8'h55, 3'd0, 8'h1B},  // R2 low byte dropped
        {4'd2, 1'b1, 3'd3, 8'h03, 3'd3, 8'h83},  // R2 LCR dropped
        {4'd3, 1'b0, 3'd3, 8'h03, 3'd3, 8'h03},  // R3 LCR direct
        {4'd6, 1'b0, 3'd1, 8'h0F, 3'd1, 8'h0F},  // R6 offset 1 is IER
        {4'd2, 1'b1, 3'd3, 8'h83, 3'd3, 8'h03},  // R2 access bit dropped
        {4'd6, 1'b1, 3'd1, 8'h05, 3'd1, 8'h05},  // R6 high write lands in IER
        {4'd1, 1'b1, 3'd5, 8'h00, 3'd7, 8'h01},  // R1 busy reads 1
        {4'd1, 1'b0, 3'd5, 8'h00, 3'd7, 8'h00}   // R1 busy reads 0
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10", {8'h0, line_ctrl}, 16'h0003);
        check("R10", divisor, 16'h0001);
        check("R10", {8'h0, int_en}, 16'h0000);
        check("R10", {15'h0, loopback}, 16'h0000);
        rd(3'd6, r); check("R10", {8'h0, r}, 16'h0000);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            tx_shifting = VEC[i][22];
            wr(VEC[i][21:19], VEC[i][18:11]);
            rd(VEC[i][10:8], r);
            n_chk++;
            if (r !== VEC[i][7:0]) begin
                n_fail++;
                $display("FAIL R%0d vector %0d: actual 0x%0h expected 0x%0h",
                         VEC[i][26:23], i, r, VEC[i][7:0]);
            end
        end
        check("R3", divisor, 16'h021B);
        check("R6", {8'h0, int_en}, 16'h0005);
        rd(3'd0, r); check("R6", {8'h0, r}, 16'h00A5);

        // R1 other busy sources
        rx_active = 1'b1; rd(3'd7, r); check("R1", {8'h0, r}, 16'h0001);
        rx_active = 1'b0; tx_fifo_empty = 1'b0;
        rd(3'd7, r); check("R1", {8'h0, r}, 16'h0001);

        // R4 staging while busy (FIFO not empty)
        wr(3'd6, 8'h01);
        wr(3'd3, 8'h87);
        check("R4", {8'h0, line_ctrl}, 16'h0003);
        rd(3'd3, r); check("R4", {8'h0, r}, 16'h0003);
        wr(3'd0, 8'h34);
        wr(3'd1, 8'h12);
        check("R4", divisor, 16'h021B);
        check("R6", {8'h0, int_en}, 16'h0005);
        wr(3'd3, 8'h07);
        // R5 update
        wr(3'd6, 8'h03);
        rd(3'd6, r); check("R5", {8'h0, r}, 16'h0003);
        check("R5", divisor, 16'h021B);
        @(negedge clk);
        check("R5", divisor, 16'h1234);
        check("R5", {8'h0, line_ctrl}, 16'h0007);
        rd(3'd6, r); check("R5", {8'h0, r}, 16'h0001);

        // R11 discard staged access bit
        wr(3'd3, 8'h80);
        wr(3'd6, 8'h00);
        wr(3'd1, 8'h09);
        check("R11", {8'h0, int_en}, 16'h0009);
        check("R11", divisor, 16'h1234);
        check("R11", {8'h0, line_ctrl}, 16'h0007);
        // R5 update ignored with enable clear
        wr(3'd6, 8'h02);
        rd(3'd6, r); check("R5", {8'h0, r}, 16'h0000);
        @(negedge clk);
        check("R5", {8'h0, line_ctrl}, 16'h0007);

        // R8 FIFO clear strobes
        @(negedge clk);
        reg_addr = 3'd2; reg_wdata = 8'h06; reg_wr = 1'b1;
        #1;
        check("R8", {14'h0, clr_rx_fifo, clr_tx_fifo}, 16'h0003);
        reg_wdata = 8'h02;
        #1;
        check("R8", {14'h0, clr_rx_fifo, clr_tx_fifo}, 16'h0002);
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
        check("R8", {14'h0, clr_rx_fifo, clr_tx_fifo}, 16'h0000);

        // R7 loopback waits for receiver idle
        tx_fifo_empty = 1'b1;
        rx_active = 1'b1;
        wr(3'd4, 8'h10);
        rd(3'd4, r); check("R7", {8'h0, r}, 16'h0010);
        repeat (3) @(negedge clk);
        check("R7", {15'h0, loopback}, 16'h0000);
        rx_active = 1'b0;
        @(negedge clk);
        check("R7", {15'h0, loopback}, 16'h0001);
        wr(3'd4, 8'h00);
        check("R7", {15'h0, loopback}, 16'h0001);
        @(negedge clk);
        check("R7", {15'h0, loopback}, 16'h0000);

        // R9 build without gating accepts busy writes
        tx_shifting = 1'b1;
        wr(3'd3, 8'h1F);
        check("R9", {8'h0, c_line_ctrl}, 16'h001F);
        check("R2", {8'h0, line_ctrl}, 16'h0007);
        tx_shifting = 1'b0;

        done = 1'b1;
        finish_run();
    end
endmodule